// File: doc/BRIEF.md
# Load/Store Byte-Lane Aligner

This unit sits between a 32-bit core datapath and a byte-addressed data memory. The memory has a 32-bit data bus and one write enable per byte. Consecutive words in that memory are four addresses apart. Byte lanes are numbered big-endian: address offset 0 is the most significant byte, bits 31:24.

On the store side the unit is purely combinational. It takes the register value, the two low address bits and an access width. It copies the relevant low bytes of the register into every lane they could occupy, and it produces a byte-enable mask that opens only the lanes the access covers. An address that does not suit the access width raises a misaligned flag, and in that case no enable is asserted.

On the load side the request fields (access kind, zero-extend flag, offset and a 16-bit immediate) are registered in the request cycle. In the following cycle the unit picks the addressed byte or halfword out of the memory word returned in that cycle and sign- or zero-extends it to 32 bits. The same path also forms the load-upper-immediate result, which puts the immediate in the high half and zeros in the low half.

Top module: `lsu_byte_align`

## Requirements
- R1: Access kinds are encoded 0 = byte, 1 = halfword, 2 = word and 3 = upper-immediate. Bit i of `mem_be` enables `mem_wdata[8i+7:8i]`. With `st_en` high, an aligned byte store at offset o enables only bit 3-o, a halfword store at offset 0 enables 4'b1100, a halfword store at offset 2 enables 4'b0011, and a word store enables 4'b1111.
- R2: `mem_wdata` is the low byte of `st_data` repeated four times for a byte store, the low halfword repeated twice for a halfword store, and `st_data` unchanged for the word and upper-immediate kinds.
- R3: With `st_en` high, a halfword store at an odd offset or a word store at a nonzero offset sets `st_misaligned` and drives `mem_be` to zero.
- R4: When `st_en` is low, or the store kind is 3, `mem_be` is zero. When `st_en` is low, `st_misaligned` is also zero.
- R5: A byte load returns the byte in lane 3-o of `mem_rdata`. The byte is sign-extended when `ld_unsigned` is 0 and zero-extended when it is 1.
- R6: A halfword load at offset 0 returns `mem_rdata[31:16]`, and at offset 2 it returns `mem_rdata[15:0]`. The halfword is sign-extended when `ld_unsigned` is 0 and zero-extended when it is 1.
- R7: A word load at offset 0 returns `mem_rdata` unchanged.
- R8: An upper-immediate request returns `{ld_imm, 16'h0000}` for every offset and extension flag, and it never flags misalignment.
- R9: `ld_valid` is high exactly in the cycle after a cycle with `ld_req` high. The kind, flag, offset and immediate of the result are those registered in the request cycle. `mem_rdata` is taken from the result cycle.
- R10: A halfword load at an odd offset, or a word load at a nonzero offset, sets `ld_misaligned` and returns zero. Outside a result cycle, `ld_result` and `ld_misaligned` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_en | input | 1 | Store request this cycle |
| st_size | input | 2 | Store access kind |
| st_addr_lo | input | 2 | Low address bits of the store |
| st_data | input | 32 | Register value to store |
| mem_wdata | output | 32 | Lane-replicated write data |
| mem_be | output | 4 | Per-byte write enables |
| st_misaligned | output | 1 | Store address does not suit its width |
| ld_req | input | 1 | Load or upper-immediate request |
| ld_op | input | 2 | Load access kind |
| ld_unsigned | input | 1 | Zero-extend instead of sign-extend |
| ld_addr_lo | input | 2 | Low address bits of the load |
| ld_imm | input | 16 | Immediate for the upper-immediate kind |
| mem_rdata | input | 32 | Memory word, valid in the result cycle |
| ld_valid | output | 1 | Result cycle indicator |
| ld_result | output | 32 | Extended register value |
| ld_misaligned | output | 1 | Load address does not suit its width |

## Verification
Every store kind is driven at every offset with `st_en` both high and low. Three register values are used, and their bytes all differ, so a wrong lane replication or a wrong enable bit shows up as a distinct value. Every load kind is swept with both extension flags at every offset, against four memory words. In those words the sign bit is set in some lanes and clear in others, so a sign-versus-zero mix-up, a swapped lane and a little-endian lane order all give different results. Idle cycles after each result separate a registered request from one that leaks into the next cycle.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;
    localparam int WORD_W = 32;
    localparam int BYTE_W = 8;
    localparam int HALF_W = 2 * BYTE_W;
    localparam int LANES  = WORD_W / BYTE_W;
    localparam int OFS_W  = $clog2(LANES);

    typedef enum logic [1:0] {
        ACC_BYTE  = 2'd0,
        ACC_HALF  = 2'd1,
        ACC_WORD  = 2'd2,
        ACC_UPPER = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic              valid;
        acc_kind_e         kind;
        logic              zext;
        logic [OFS_W-1:0]  ofs;
        logic [HALF_W-1:0] imm;
    } ld_req_t;

    function automatic logic is_misaligned(acc_kind_e k, logic [OFS_W-1:0] ofs);
        case (k)
            ACC_HALF: return ofs[0];
            ACC_WORD: return |ofs;
            default:  return 1'b0;
        endcase
    endfunction

    // big-endian: offset 0 lives in the top lane
    function automatic int lane_of(logic [OFS_W-1:0] ofs);
        return LANES - 1 - int'(ofs);
    endfunction
endpackage

// File: rtl/store_lane_gen.sv
module store_lane_gen
    import lsu_lane_pkg::*;
(
    input  logic              en,
    input  acc_kind_e         kind,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [WORD_W-1:0] data,
    output logic [WORD_W-1:0] wdata,
    output logic [LANES-1:0]  be,
    output logic              misal
);
    localparam logic [LANES-1:0] ONE_LANE  = LANES'(1);
    localparam logic [LANES-1:0] TWO_LANES = LANES'(3);

    logic [LANES-1:0] base_be;

    always_comb begin
        base_be = '0;
        wdata   = data;
        case (kind)
            ACC_BYTE: begin
                wdata   = {LANES{data[BYTE_W-1:0]}};
                base_be = ONE_LANE << lane_of(ofs);
            end
            ACC_HALF: begin
                wdata   = {(LANES/2){data[HALF_W-1:0]}};
                base_be = ofs[OFS_W-1] ? TWO_LANES : (TWO_LANES << 2);
            end
            ACC_WORD: base_be = '1;
            default:  base_be = '0;
        endcase
        misal = en && is_misaligned(kind, ofs);
        be    = (en && !misal) ? base_be : '0;
    end
endmodule

// File: rtl/load_lane_ext.sv
module load_lane_ext
    import lsu_lane_pkg::*;
(
    input  ld_req_t           req,
    input  logic [WORD_W-1:0] rdata,
    output logic [WORD_W-1:0] result,
    output logic              misal
);
    logic [BYTE_W-1:0] byte_sel;
    logic [HALF_W-1:0] half_sel;
    logic              bsign;
    logic              hsign;

    always_comb begin
        byte_sel = rdata[BYTE_W*lane_of(req.ofs) +: BYTE_W];
        half_sel = req.ofs[OFS_W-1] ? rdata[HALF_W-1:0] : rdata[WORD_W-1:HALF_W];
        bsign    = !req.zext && byte_sel[BYTE_W-1];
        hsign    = !req.zext && half_sel[HALF_W-1];
        misal    = req.valid && is_misaligned(req.kind, req.ofs);
        case (req.kind)
            ACC_BYTE: result = {{(WORD_W-BYTE_W){bsign}}, byte_sel};
            ACC_HALF: result = {{(WORD_W-HALF_W){hsign}}, half_sel};
            ACC_WORD: result = rdata;
            default:  result = {req.imm, {(WORD_W-HALF_W){1'b0}}};
        endcase
        if (!req.valid || misal) result = '0;
    end
endmodule

// File: rtl/lsu_byte_align.sv
module lsu_byte_align
    import lsu_lane_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        st_en,
    input  logic [1:0]  st_size,
    input  logic [1:0]  st_addr_lo,
    input  logic [31:0] st_data,
    output logic [31:0] mem_wdata,
    output logic [3:0]  mem_be,
    output logic        st_misaligned,
    input  logic        ld_req,
    input  logic [1:0]  ld_op,
    input  logic        ld_unsigned,
    input  logic [1:0]  ld_addr_lo,
    input  logic [15:0] ld_imm,
    input  logic [31:0] mem_rdata,
    output logic        ld_valid,
    output logic [31:0] ld_result,
    output logic        ld_misaligned
);
    ld_req_t req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
        end else begin
            req_q.valid <= ld_req;
            req_q.kind  <= acc_kind_e'(ld_op);
            req_q.zext  <= ld_unsigned;
            req_q.ofs   <= ld_addr_lo;
            req_q.imm   <= ld_imm;
        end
    end

    store_lane_gen u_st (
        .en    (st_en),
        .kind  (acc_kind_e'(st_size)),
        .ofs   (st_addr_lo),
        .data  (st_data),
        .wdata (mem_wdata),
        .be    (mem_be),
        .misal (st_misaligned)
    );

    load_lane_ext u_ld (
        .req    (req_q),
        .rdata  (mem_rdata),
        .result (ld_result),
        .misal  (ld_misaligned)
    );

    assign ld_valid = req_q.valid;
endmodule

// File: rtl/lsu_byte_align_chk.sv
module lsu_byte_align_chk (
    input logic        clk,
    input logic        rst,
    input logic        st_en,
    input logic [1:0]  st_size,
    input logic [3:0]  mem_be,
    input logic        st_misaligned,
    input logic        ld_req,
    input logic [1:0]  ld_op,
    input logic        ld_unsigned,
    input logic        ld_valid,
    input logic [31:0] ld_result,
    input logic        ld_misaligned
);
    assert_be_width_R1: assert property (@(posedge clk) disable iff (rst)
        $countones(mem_be) != 3);

    assert_misal_no_write_R3: assert property (@(posedge clk) disable iff (rst)
        st_misaligned |-> mem_be == 4'b0000);

    assert_idle_store_R4: assert property (@(posedge clk) disable iff (rst)
        (!st_en || st_size == 2'd3) |-> mem_be == 4'b0000);

    assert_byte_sign_R5: assert property (@(posedge clk) disable iff (rst)
        (ld_req && ld_op == 2'd0 && !ld_unsigned) |=>
            ld_result[31:8] == {24{ld_result[7]}});

    assert_upper_low_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (ld_req && ld_op == 2'd3) |=> (ld_result[15:0] == 16'h0 && !ld_misaligned));

    assert_valid_follows_req_R9: assert property (@(posedge clk) disable iff (rst)
        ld_req |=> ld_valid);

    assert_no_spurious_valid_R9: assert property (@(posedge clk) disable iff (rst)
        !ld_req |=> !ld_valid);

    assert_misal_zero_R10: assert property (@(posedge clk) disable iff (rst)
        ld_misaligned |-> (ld_result == 32'h0 && ld_valid));
endmodule

bind lsu_byte_align lsu_byte_align_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .st_en         (st_en),
    .st_size       (st_size),
    .mem_be        (mem_be),
    .st_misaligned (st_misaligned),
    .ld_req        (ld_req),
    .ld_op         (ld_op),
    .ld_unsigned   (ld_unsigned),
    .ld_valid      (ld_valid),
    .ld_result     (ld_result),
    .ld_misaligned (ld_misaligned)
);

// File: tb/lsu_byte_align_tb.sv
module lsu_byte_align_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        st_en = 1'b0;
    logic [1:0]  st_size = '0;
    logic [1:0]  st_addr_lo = '0;
    logic [31:0] st_data = '0;
    logic [31:0] mem_wdata;
    logic [3:0]  mem_be;
    logic        st_misaligned;
    logic        ld_req = 1'b0;
    logic [1:0]  ld_op = '0;
    logic        ld_unsigned = 1'b0;
    logic [1:0]  ld_addr_lo = '0;
    logic [15:0] ld_imm = '0;
    logic [31:0] mem_rdata = '0;
    logic        ld_valid;
    logic [31:0] ld_result;
    logic        ld_misaligned;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    lsu_byte_align u_dut (.*);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_store(logic en, logic [1:0] sz, logic [1:0] o, logic [31:0] d);
        logic [3:0]  ebe;
        logic [31:0] ewd;
        logic        emis;
        @(negedge clk);
        st_en = en; st_size = sz; st_addr_lo = o; st_data = d;
        ewd = d; ebe = 4'b0000; emis = 1'b0;
        case (sz)
            2'd0: begin ewd = {4{d[7:0]}};  ebe = 4'b1000 >> o; end
            2'd1: begin ewd = {2{d[15:0]}}; emis = o[0]; ebe = (o == 2'd0) ? 4'b1100 : 4'b0011; end
            2'd2: begin emis = (o != 2'd0); ebe = 4'b1111; end
            default: ebe = 4'b0000;
        endcase
        if (!en) begin emis = 1'b0; ebe = 4'b0000; end
        if (emis) ebe = 4'b0000;
        #1;
        check("R1 store byte enables", {28'h0, mem_be}, {28'h0, ebe});
        check("R2 store lane data", mem_wdata, ewd);
        check(en ? "R3 store misaligned flag" : "R4 idle store flag",
              {31'h0, st_misaligned}, {31'h0, emis});
    endtask

    task automatic do_load(logic [1:0] op, logic uns, logic [1:0] o, logic [15:0] imm, logic [31:0] d);
        logic [31:0] exp;
        logic        emis;
        logic [7:0]  b;
        logic [15:0] h;
        string       tag;
        emis = 1'b0;
        b = 8'((d >> (8 * (3 - int'(o)))) & 32'hff);
        h = o[1] ? d[15:0] : d[31:16];
        case (op)
            2'd0: begin tag = "R5 byte load";
                exp = (!uns && b[7]) ? {24'hffffff, b} : {24'h0, b}; end
            2'd1: begin tag = "R6 half load"; emis = o[0];
                exp = (!uns && h[15]) ? {16'hffff, h} : {16'h0, h}; end
            2'd2: begin tag = "R7 word load"; emis = (o != 2'd0); exp = d; end
            default: begin tag = "R8 upper immediate"; exp = {imm, 16'h0}; end
        endcase
        if (emis) begin exp = 32'h0; tag = "R10 misaligned load"; end
        @(negedge clk);
        ld_req = 1'b1; ld_op = op; ld_unsigned = uns; ld_addr_lo = o; ld_imm = imm;
        @(posedge clk);
        #1;
        ld_req = 1'b0; ld_op = ~op; ld_unsigned = ~uns; ld_addr_lo = ~o; ld_imm = ~imm;
        mem_rdata = d;
        #1;
        check("R9 result valid", {31'h0, ld_valid}, 32'h1);
        check(tag, ld_result, exp);
        check("R10 load misaligned flag", {31'h0, ld_misaligned}, {31'h0, emis});
        @(posedge clk);
        #1;
        check("R9 no valid without request", {31'h0, ld_valid}, 32'h0);
        check("R10 idle result zero", ld_result, 32'h0);
    endtask

    initial begin
        logic [31:0] spat [3];
        logic [31:0] lpat [4];
        spat[0] = 32'h12345678; spat[1] = 32'hCAFE80F1; spat[2] = 32'h89ABCDEF;
        lpat[0] = 32'h80FF7F01; lpat[1] = 32'h017F80FE;
        lpat[2] = 32'hA5C33C5A; lpat[3] = 32'hFFFF0000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R9 reset valid low", {31'h0, ld_valid}, 32'h0);
        check("R4 reset enables low", {28'h0, mem_be}, 32'h0);
        for (int e = 0; e < 2; e++)
            for (int s = 0; s < 4; s++)
                for (int o = 0; o < 4; o++)
                    for (int p = 0; p < 3; p++)
                        do_store(e[0], s[1:0], o[1:0], spat[p]);
        for (int op = 0; op < 4; op++)
            for (int u = 0; u < 2; u++)
                for (int o = 0; o < 4; o++)
                    for (int p = 0; p < 4; p++)
                        do_load(op[1:0], u[0], o[1:0], 16'hB00F ^ 16'(p * 16'h1111), lpat[p]);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule